// File: doc/BRIEF.md
# Linked-List Block FIFO Manager

This block keeps the bookkeeping for a packet memory that is cut into equal blocks of sixteen bytes and shared among several channels. Software links blocks into one closed ring per channel by programming a next-block table. It then names one block of that ring as the channel's first block and gives the channel its ring length and two thresholds. A producer asks for the block it should fill next, and a consumer asks for the block it should empty next. Each accepted request moves that side one step around the channel's ring.

Both thresholds are counted in whole blocks. A drain request goes up when the number of filled blocks reaches the upper threshold, which serves a receive direction. A refill request goes up when the number of filled blocks has dropped to the lower threshold, which serves a transmit direction. A producer request into a full ring is refused and sets a sticky overflow flag. A consumer request on an empty ring is refused and sets a sticky underflow flag.

Top module: `llf_block_fifo_mgr`

## Requirements
- R1: An accepted fill request on a channel moves that channel's tail to the next-block entry of the block just filled. `wr_block` always shows the tail of channel `wr_ch`, and a ring visits its blocks in link order from the first block and wraps back to it.
- R2: An accepted drain request on a channel moves that channel's head to the next-block entry of its current head. `rd_block` always shows the head of channel `rd_ch`.
- R3: A fill request on a channel whose filled count equals its ring length is refused. The tail does not move, and the channel's bit in `ovf_flag` is set and stays set.
- R4: A drain request on a channel whose filled count is zero is refused. The head does not move, and the channel's bit in `udf_flag` is set and stays set.
- R5: `drain_req[c]` is 1 exactly when the filled count is at least the upper threshold and that threshold lies in 1 to length-1. A threshold of 0, or one equal to or above the length, never raises it.
- R6: `refill_req[c]` is 1 exactly when the filled count is less than or equal to the lower threshold.
- R7: A fill and a drain on the same channel in the same cycle are each judged against the count before that cycle. With 0 < count < length both are accepted and the count is unchanged. At full only the drain is accepted; at empty only the fill is accepted.
- R8: Writing a channel's first block loads both its head and its tail with that block and clears its count and both flags. No other channel changes.
- R9: Reset (`rst_n` low at a clock edge) clears every count and flag and puts every head and tail on its channel's first block. The next-block table, first blocks, lengths and thresholds are kept through reset.
- R10: The configuration write is selected by `cfg_kind`: 0 next-block entry of block `cfg_idx`, 1 first block, 2 ring length, 3 upper threshold, 4 lower threshold. For kinds 1 to 4 the channel is taken from the low bits of `cfg_idx`. `cfg_data` is 10 bits wide; for kinds 0 and 1 its low 9 bits are a block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Which setting is written (R10) |
| cfg_idx | input | 9 | Block index or channel index |
| cfg_data | input | 10 | Value written |
| wr_req | input | 1 | Fill one block of channel `wr_ch` |
| wr_ch | input | 2 | Producer channel |
| rd_req | input | 1 | Drain one block of channel `rd_ch` |
| rd_ch | input | 2 | Consumer channel |
| wr_block | output | 9 | Block to fill next on `wr_ch` |
| rd_block | output | 9 | Block to drain next on `rd_ch` |
| drain_req | output | 4 | Per-channel upper-threshold request |
| refill_req | output | 4 | Per-channel lower-threshold request |
| ovf_flag | output | 4 | Per-channel sticky overflow |
| udf_flag | output | 4 | Per-channel sticky underflow |

## Verification
The hardest case to reach is a fill and a drain landing on the same channel in one cycle while the ring is exactly full or exactly empty. At those two counts one of the two requests must be refused while the other moves its pointer. The bench first fills a five-block ring whose first block sits in the middle of the link order. It then issues a combined request at full, a second one at an intermediate count, and a third one on a freshly restarted empty ring. After each step it reads both pointers and the flags at the ports. Threshold legality is checked on the same full ring by stepping the upper threshold through 0, the ring length, and one less than the length.

// File: rtl/llf_pkg.sv
// Shared types for the linked-list block FIFO manager.
// Assumes: configuration kinds are encoded in three bits.
package llf_pkg;
    typedef enum logic [2:0] {
        CFG_NEXT  = 3'd0,
        CFG_START = 3'd1,
        CFG_LEN   = 3'd2,
        CFG_HWM   = 3'd3,
        CFG_LWM   = 3'd4
    } cfg_kind_e;
endpackage

// File: rtl/llf_link_table.sv
// Next-block table: one entry per block, naming the block that follows it.
// Assumes: written only by configuration, never reset; two asynchronous read ports.
module llf_link_table #(
    parameter int NUM_BLOCKS = 512,
    parameter int IDX_W      = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [IDX_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [IDX_W-1:0] rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [IDX_W-1:0] rdata_b
);
    logic [IDX_W-1:0] link_mem [NUM_BLOCKS];

    // Store a software-written link.
    always_ff @(posedge clk) begin
        if (we) link_mem[waddr] <= wdata;
    end

    // Look up the successor for the producer and consumer sides.
    always_comb begin
        rdata_a = link_mem[raddr_a];
        rdata_b = link_mem[raddr_b];
    end
endmodule

// File: rtl/llf_chan_ctrl.sv
// Per-channel state: ring settings, head and tail, filled count, flags and thresholds.
// Assumes: tail_next/head_next carry the link of this channel's own tail/head whenever
// wr_sel/rd_sel is high. Settings are kept through reset; the run-time state is not.
module llf_chan_ctrl #(
    parameter int IDX_W = 9,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start_we,
    input  logic             cfg_len_we,
    input  logic             cfg_hwm_we,
    input  logic             cfg_lwm_we,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic             wr_sel,
    input  logic             rd_sel,
    input  logic [IDX_W-1:0] tail_next,
    input  logic [IDX_W-1:0] head_next,
    output logic [IDX_W-1:0] tail_o,
    output logic [IDX_W-1:0] head_o,
    output logic             drain_o,
    output logic             refill_o,
    output logic             ovf_o,
    output logic             udf_o
);
    logic [IDX_W-1:0] start_q, head_q, tail_q;
    logic [CNT_W-1:0] len_q, hwm_q, lwm_q, count_q;
    logic             ovf_q, udf_q;
    logic             full, empty, wr_ok, rd_ok, hwm_legal;

    // Capture this channel's ring settings.
    always_ff @(posedge clk) begin
        if (cfg_start_we) start_q <= cfg_data[IDX_W-1:0];
        if (cfg_len_we)   len_q   <= cfg_data;
        if (cfg_hwm_we)   hwm_q   <= cfg_data;
        if (cfg_lwm_we)   lwm_q   <= cfg_data;
    end

    // Decide acceptance from the count held before this cycle.
    always_comb begin
        full      = (count_q == len_q);
        empty     = (count_q == '0);
        wr_ok     = wr_sel && !full;
        rd_ok     = rd_sel && !empty;
        hwm_legal = (hwm_q != '0) && (hwm_q < len_q);
    end

    // Advance pointers and count, and latch the error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= start_q;
            tail_q  <= start_q;
            count_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else if (cfg_start_we) begin
            head_q  <= cfg_data[IDX_W-1:0];
            tail_q  <= cfg_data[IDX_W-1:0];
            count_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else begin
            if (wr_ok) tail_q <= tail_next;
            if (rd_ok) head_q <= head_next;
            count_q <= count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
            if (wr_sel && full)  ovf_q <= 1'b1;
            if (rd_sel && empty) udf_q <= 1'b1;
        end
    end

    // Compare the filled count with both thresholds.
    always_comb begin
        drain_o  = hwm_legal && (count_q >= hwm_q);
        refill_o = (count_q <= lwm_q);
        tail_o   = tail_q;
        head_o   = head_q;
        ovf_o    = ovf_q;
        udf_o    = udf_q;
    end

    // R3: a fill into a full ring leaves the tail in place and flags overflow.
    a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && count_q == len_q && !cfg_start_we) |=> ($stable(tail_q) && ovf_q));

    // R3: overflow stays set until the ring is restarted.
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !cfg_start_we) |=> ovf_q);

    // R4: a drain from an empty ring leaves the head in place and flags underflow.
    a_r4_empty_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && count_q == '0 && !cfg_start_we) |=> ($stable(head_q) && udf_q));

    // R7: a fill and a drain accepted together leave the count unchanged.
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && rd_sel && count_q != '0 && count_q != len_q && !cfg_start_we)
        |=> $stable(count_q));

    // R8: a restart leaves an empty ring with head on tail and no flags.
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start_we |=> (count_q == '0 && head_q == tail_q && !ovf_q && !udf_q));
endmodule

// File: rtl/llf_block_fifo_mgr.sv
// Top of the linked-list block FIFO manager: decodes configuration, routes producer
// and consumer requests to channels, and shares one next-block table among them.
// Assumes: wr_ch and rd_ch are below NUM_CH.
module llf_block_fifo_mgr
    import llf_pkg::*;
#(
    parameter int NUM_BLOCKS = 512,
    parameter int NUM_CH     = 4,
    localparam int IDX_W     = $clog2(NUM_BLOCKS),
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1),
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CNT_W-1:0]  cfg_data,
    input  logic              wr_req,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              rd_req,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [IDX_W-1:0]  wr_block,
    output logic [IDX_W-1:0]  rd_block,
    output logic [NUM_CH-1:0] drain_req,
    output logic [NUM_CH-1:0] refill_req,
    output logic [NUM_CH-1:0] ovf_flag,
    output logic [NUM_CH-1:0] udf_flag
);
    cfg_kind_e        kind;
    logic             link_we;
    logic [IDX_W-1:0] tail_arr [NUM_CH];
    logic [IDX_W-1:0] head_arr [NUM_CH];
    logic [IDX_W-1:0] tail_link, head_link;

    // Classify the configuration write.
    always_comb begin
        kind    = cfg_kind_e'(cfg_kind);
        link_we = cfg_we && (kind == CFG_NEXT);
    end

    llf_link_table #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_links (
        .clk     (clk),
        .we      (link_we),
        .waddr   (cfg_idx),
        .wdata   (cfg_data[IDX_W-1:0]),
        .raddr_a (wr_block),
        .rdata_a (tail_link),
        .raddr_b (rd_block),
        .rdata_b (head_link)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        // Match configuration writes that target this channel.
        always_comb hit = cfg_we && (cfg_idx[CH_W-1:0] == CH_W'(c));

        llf_chan_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_start_we (hit && kind == CFG_START),
            .cfg_len_we   (hit && kind == CFG_LEN),
            .cfg_hwm_we   (hit && kind == CFG_HWM),
            .cfg_lwm_we   (hit && kind == CFG_LWM),
            .cfg_data     (cfg_data),
            .wr_sel       (wr_req && wr_ch == CH_W'(c)),
            .rd_sel       (rd_req && rd_ch == CH_W'(c)),
            .tail_next    (tail_link),
            .head_next    (head_link),
            .tail_o       (tail_arr[c]),
            .head_o       (head_arr[c]),
            .drain_o      (drain_req[c]),
            .refill_o     (refill_req[c]),
            .ovf_o        (ovf_flag[c]),
            .udf_o        (udf_flag[c])
        );
    end

    // Show the selected channels' tail and head.
    always_comb begin
        wr_block = tail_arr[wr_ch];
        rd_block = head_arr[rd_ch];
    end

    // R9: the cycle after reset no channel carries a flag.
    a_r9_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (ovf_flag == '0 && udf_flag == '0));
endmodule

// File: tb/llf_block_fifo_mgr_bench.sv
// Directed bench for the linked-list block FIFO manager.
module llf_block_fifo_mgr_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_kind = '0;
    logic [8:0] cfg_idx = '0;
    logic [9:0] cfg_data = '0;
    logic       wr_req = 1'b0, rd_req = 1'b0;
    logic [1:0] wr_ch = '0, rd_ch = '0;
    logic [8:0] wr_block, rd_block;
    logic [3:0] drain_req, refill_req, ovf_flag, udf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    llf_block_fifo_mgr u_llf_block_fifo_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .wr_req(wr_req), .wr_ch(wr_ch),
        .rd_req(rd_req), .rd_ch(rd_ch), .wr_block(wr_block), .rd_block(rd_block),
        .drain_req(drain_req), .refill_req(refill_req),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // R10 encoding: 0 link, 1 first block, 2 length, 3 upper, 4 lower threshold.
    task automatic cfg(input int kind, input int idx, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 9'(idx); cfg_data = 10'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One cycle of producer and/or consumer requests; selects stay for peeking.
    task automatic op(input bit w, input int wc, input bit r, input int rc);
        @(negedge clk);
        wr_req = w; wr_ch = 2'(wc); rd_req = r; rd_ch = 2'(rc);
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        #1;
    endtask

    task automatic peek(input int ch);
        wr_ch = 2'(ch); rd_ch = 2'(ch);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Ch0 ring 0->1->2->3, ch1 ring 10->20->7->100->511 starting at 20.
    task automatic t_configure();
        for (int b = 0; b < 4; b++) cfg(0, b, (b + 1) % 4);
        cfg(0, 10, 20); cfg(0, 20, 7); cfg(0, 7, 100); cfg(0, 100, 511); cfg(0, 511, 10);
        cfg(1, 0, 0);  cfg(2, 0, 4); cfg(3, 0, 3); cfg(4, 0, 1);
        cfg(1, 1, 20); cfg(2, 1, 5); cfg(3, 1, 0); cfg(4, 1, 2);
        for (int c = 2; c < 4; c++) begin
            cfg(1, c, 0); cfg(2, c, 4); cfg(3, c, 2); cfg(4, c, 1);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        peek(0);
        check("R9 ch0 tail at first block", int'(wr_block), 0);
        peek(1);
        check("R9 ch1 head at first block", int'(rd_block), 20);
        check("R9 overflow clear", int'(ovf_flag), 0);
        check("R9 underflow clear", int'(udf_flag), 0);
        check("R9 drain low", int'(drain_req[1:0]), 0);
        check("R9 refill high when empty", int'(refill_req[1:0]), 3);
    endtask

    task automatic t_fill_walk();
        int exp_tail [4] = '{1, 2, 3, 0};
        for (int k = 1; k <= 4; k++) begin
            op(1, 0, 0, 0);
            check("R1 R10 ch0 tail walk", int'(wr_block), exp_tail[k-1]);
            check("R5 ch0 drain vs count", int'(drain_req[0]), (k >= 3) ? 1 : 0);
            check("R6 ch0 refill vs count", int'(refill_req[0]), (k <= 1) ? 1 : 0);
        end
    endtask

    task automatic t_overflow();
        op(1, 0, 0, 0);
        check("R3 ch0 overflow set", int'(ovf_flag[0]), 1);
        check("R3 ch0 tail held", int'(wr_block), 0);
        check("R3 other channel clean", int'(ovf_flag[1]), 0);
    endtask

    task automatic t_drain_walk();
        int exp_head [4] = '{1, 2, 3, 0};
        for (int k = 1; k <= 4; k++) begin
            op(0, 0, 1, 0);
            check("R2 ch0 head walk", int'(rd_block), exp_head[k-1]);
            check("R6 ch0 refill as count falls", int'(refill_req[0]), (4 - k <= 1) ? 1 : 0);
        end
        op(0, 0, 1, 0);
        check("R4 ch0 underflow set", int'(udf_flag[0]), 1);
        check("R4 ch0 head held", int'(rd_block), 0);
        check("R3 ch0 overflow still set", int'(ovf_flag[0]), 1);
    endtask

    task automatic t_restart();
        op(0, 1, 1, 1);
        check("R4 ch1 underflow on empty", int'(udf_flag[1]), 1);
        cfg(1, 0, 2);
        #1; peek(0);
        check("R8 ch0 tail loaded", int'(wr_block), 2);
        check("R8 ch0 head loaded", int'(rd_block), 2);
        check("R8 ch0 flags cleared", int'({ovf_flag[0], udf_flag[0]}), 0);
        check("R8 ch1 untouched", int'(udf_flag[1]), 1);
    endtask

    task automatic t_mid_ring_and_threshold();
        int exp_tail [5] = '{7, 100, 511, 10, 20};
        cfg(1, 1, 20);
        for (int k = 1; k <= 5; k++) begin
            op(1, 1, 0, 1);
            check("R1 ch1 mid-ring tail walk", int'(wr_block), exp_tail[k-1]);
            check("R5 ch1 zero threshold never drains", int'(drain_req[1]), 0);
        end
        cfg(3, 1, 5);
        #1;
        check("R5 ch1 threshold equal to length ignored", int'(drain_req[1]), 0);
        cfg(3, 1, 4);
        #1;
        check("R5 ch1 legal threshold drains", int'(drain_req[1]), 1);
    endtask

    task automatic t_same_cycle();
        op(1, 1, 1, 1);
        check("R7 full: drain accepted", int'(rd_block), 7);
        check("R7 full: tail held", int'(wr_block), 20);
        check("R7 full: fill refused", int'(ovf_flag[1]), 1);
        op(1, 1, 1, 1);
        check("R7 mid: head moves", int'(rd_block), 100);
        check("R7 mid: tail moves", int'(wr_block), 7);
        check("R7 mid: count kept at threshold", int'(drain_req[1]), 1);
        op(1, 0, 1, 0);
        check("R7 empty: drain refused", int'(udf_flag[0]), 1);
        check("R7 empty: fill accepted", int'(wr_block), 3);
        check("R7 empty: head held", int'(rd_block), 2);
    endtask

    task automatic t_reset_keeps_config();
        do_reset();
        peek(1);
        check("R9 ch1 tail back to first block", int'(wr_block), 20);
        check("R9 flags cleared", int'({ovf_flag, udf_flag}), 0);
        check("R9 threshold kept", int'(refill_req[1]), 1);
        op(1, 1, 0, 1);
        check("R9 links kept", int'(wr_block), 7);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        t_configure();
        t_reset_state();
        t_fill_walk();
        t_overflow();
        t_drain_walk();
        t_restart();
        t_mid_ring_and_threshold();
        t_same_cycle();
        t_reset_keeps_config();
        finish_run();
    end
endmodule